// File: doc/BRIEF.md
# Pulse-Swallow Feedback Frequency Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It divides a high-frequency input clock by N = 64·B + 2·A. The prescaler is built from two stages: a fixed divide-by-2 stage, followed by a dual-modulus stage that divides by either 32 or 33. Together they act as a 64/66 prescaler. Two down-counters steer the modulus. The swallow counter (A) holds the prescaler in its long modulus for the first A prescaler cycles of each output period. The pulse counter (B) sets how many prescaler cycles make up one output period.

The divider ratio comes from a 17-bit channel configuration word. The block samples this word once per output period, in the first input cycle of that period, so a change never disturbs a period that is already running. A word that breaks the counter rules raises an error flag and is replaced by the smallest legal ratio. The output is a single pulse, one input clock wide, at the end of every period. It feeds the phase/frequency detector.

Top module: `pswallow_div`

## Requirements
- R1: The configuration word carries A in bits [4:0] and B in bits [16:5], both unsigned. With a legal word, `div_o` pulses once every 64·B + 2·A input clocks.
- R2: Every `div_o` pulse lasts exactly one input clock cycle.
- R3: Within a period, the first A prescaler cycles last 66 input clocks each and the remaining B−A last 64 each. A = B (every cycle long) and A = 0 (every cycle short) are both legal.
- R4: The word is sampled in the first input cycle of each output period. A change applied mid-period leaves the current period length unchanged and takes effect in the following period.
- R5: A word with B < 3 sets `cfg_err_o` for that period, and the divider runs at the minimum ratio of 192.
- R6: A word with B < A sets `cfg_err_o` for that period, and the divider runs at the minimum ratio of 192.
- R7: `cfg_err_o` changes only when a word is sampled. It returns low in the first period that samples a legal word.
- R8: While `rst_ni` is low, `div_o` and `cfg_err_o` are low. The first period begins with the first clock after reset is released, and its first pulse follows exactly N clocks later.
- R9: The extreme legal settings A = 0, B = 3 (N = 192) and A = B = 31 (N = 2046) divide exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-frequency input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_word_i | input | 17 | Channel word: A in [4:0], B in [16:5] |
| div_o | output | 1 | Divided output, one clock wide per period |
| cfg_err_o | output | 1 | Word in effect was illegal and was replaced |

## Verification
A faulty swallow or pulse counter, or a prescaler stuck in the wrong modulus, shows at the output as a pulse that arrives early or late. This appears no later than the end of the period in which the fault occurs, so the bench compares `div_o` against a behavioural period counter on every clock. A configuration latch that samples at the wrong moment moves a pulse in the period after the mid-period change. A faulty error path shows at once on `cfg_err_o`, and also as a period other than 192.

// File: rtl/psd_pkg.sv
package psd_pkg;

   // Prescaler modulus select: short (MOD_LO) or long (MOD_LO + 1)
   typedef enum logic {
      PSD_MOD_SHORT = 1'b0,
      PSD_MOD_LONG  = 1'b1
   } psd_mod_e;

endpackage

// File: rtl/psd_cfg_decode.sv
// Splits the channel word into swallow/pulse counts and replaces illegal
// settings by the minimum legal ratio.
module psd_cfg_decode #(
   parameter int A_W   = 5,
   parameter int B_W   = 12,
   parameter int B_MIN = 3,
   localparam int CFG_W = A_W + B_W
) (
   input  logic [CFG_W-1:0] cfg_i,
   output logic [A_W-1:0]   a_o,
   output logic [B_W-1:0]   b_o,
   output logic             err_o
);

   logic [A_W-1:0] a_raw;
   logic [B_W-1:0] b_raw;
   logic           b_small;
   logic           b_below_a;

   assign a_raw     = cfg_i[A_W-1:0];
   assign b_raw     = cfg_i[CFG_W-1:A_W];
   assign b_small   = (b_raw < B_W'(B_MIN));

   generate
      if (A_W > B_W) begin : g_wide_a
         assign b_below_a = ({{(A_W-B_W){1'b0}}, b_raw} < a_raw);
      end else if (A_W < B_W) begin : g_wide_b
         assign b_below_a = (b_raw < {{(B_W-A_W){1'b0}}, a_raw});
      end else begin : g_same
         assign b_below_a = (b_raw < a_raw);
      end
   endgenerate

   always_comb begin
      err_o = b_small | b_below_a;
      if (err_o) begin
         a_o = '0;
         b_o = B_W'(B_MIN);
      end else begin
         a_o = a_raw;
         b_o = b_raw;
      end
   end

endmodule

// File: rtl/psd_prescaler.sv
// Fixed pre-divider followed by a MOD_LO/(MOD_LO+1) dual-modulus stage.
// tc_o marks the last input clock of each prescaler cycle.
module psd_prescaler
   import psd_pkg::*;
#(
   parameter int PRE_FIX = 2,
   parameter int MOD_LO  = 32,
   localparam int MC_W   = $clog2(MOD_LO + 1),
   localparam int PH_W   = (PRE_FIX > 1) ? $clog2(PRE_FIX) : 1
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  psd_mod_e mode_i,
   output logic     tc_o
);

   logic            stage_en;
   logic [MC_W-1:0] mc_q;
   logic [MC_W-1:0] mc_last;

   generate
      if (PRE_FIX == 1) begin : g_no_fix
         assign stage_en = 1'b1;
      end else begin : g_fix
         logic [PH_W-1:0] ph_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               ph_q <= '0;
            end else if (ph_q == PH_W'(PRE_FIX - 1)) begin
               ph_q <= '0;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
         end
         assign stage_en = (ph_q == PH_W'(PRE_FIX - 1));
      end
   endgenerate

   assign mc_last = (mode_i == PSD_MOD_LONG) ? MC_W'(MOD_LO) : MC_W'(MOD_LO - 1);
   assign tc_o    = stage_en && (mc_q == mc_last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mc_q <= '0;
      end else if (tc_o) begin
         mc_q <= '0;
      end else if (stage_en) begin
         mc_q <= mc_q + 1'b1;
      end
   end

endmodule

// File: rtl/psd_modctl.sv
// Swallow and pulse down-counters. Both reload in the first cycle of a
// period; the swallow counter keeps the long modulus while nonzero.
module psd_modctl
   import psd_pkg::*;
#(
   parameter int A_W = 5,
   parameter int B_W = 12
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           tc_i,
   input  logic [A_W-1:0] a_i,
   input  logic [B_W-1:0] b_i,
   input  logic           err_i,
   output psd_mod_e       mode_o,
   output logic           load_o,
   output logic           last_o,
   output logic           err_o
);

   logic [A_W-1:0] sw_q;
   logic [B_W-1:0] pc_q;
   logic           load_q;
   logic           err_q;

   assign load_o = load_q;
   assign err_o  = err_q;
   assign mode_o = (sw_q != '0) ? PSD_MOD_LONG : PSD_MOD_SHORT;
   assign last_o = tc_i && !load_q && (pc_q == B_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sw_q   <= '0;
         pc_q   <= '0;
         load_q <= 1'b1;
         err_q  <= 1'b0;
      end else begin
         load_q <= last_o;
         if (load_q) begin
            sw_q  <= a_i;
            pc_q  <= b_i;
            err_q <= err_i;
         end else if (tc_i) begin
            pc_q <= pc_q - 1'b1;
            if (sw_q != '0) begin
               sw_q <= sw_q - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
   import psd_pkg::*;
#(
   parameter int A_W     = 5,
   parameter int B_W     = 12,
   parameter int B_MIN   = 3,
   parameter int PRE_FIX = 2,
   parameter int MOD_LO  = 32,
   localparam int CFG_W  = A_W + B_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CFG_W-1:0] cfg_word_i,
   output logic             div_o,
   output logic             cfg_err_o
);

   generate
      if (A_W < 1 || B_W < 2) begin : g_bad_width
         $error("pswallow_div: counter widths too small");
      end
      if (PRE_FIX < 1) begin : g_bad_fix
         $error("pswallow_div: PRE_FIX must be at least 1");
      end
      if (MOD_LO < 2) begin : g_bad_mod
         $error("pswallow_div: MOD_LO must be at least 2");
      end
      if (B_MIN < 2 || B_MIN >= (1 << B_W)) begin : g_bad_bmin
         $error("pswallow_div: B_MIN out of range");
      end
   endgenerate

   logic [A_W-1:0] a_w;
   logic [B_W-1:0] b_w;
   logic           dec_err_w;
   psd_mod_e       mode_w;
   logic           pre_tc;
   logic           load_w;
   logic           last_w;
   logic           err_w;
   logic           div_q;

   psd_cfg_decode #(
      .A_W   (A_W),
      .B_W   (B_W),
      .B_MIN (B_MIN)
   ) u_decode (
      .cfg_i (cfg_word_i),
      .a_o   (a_w),
      .b_o   (b_w),
      .err_o (dec_err_w)
   );

   psd_prescaler #(
      .PRE_FIX (PRE_FIX),
      .MOD_LO  (MOD_LO)
   ) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_w),
      .tc_o   (pre_tc)
   );

   psd_modctl #(
      .A_W (A_W),
      .B_W (B_W)
   ) u_ctl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tc_i   (pre_tc),
      .a_i    (a_w),
      .b_i    (b_w),
      .err_i  (dec_err_w),
      .mode_o (mode_w),
      .load_o (load_w),
      .last_o (last_w),
      .err_o  (err_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= 1'b0;
      end else begin
         div_q <= last_w;
      end
   end

   assign div_o     = div_q;
   assign cfg_err_o = err_w;

endmodule

// File: rtl/psd_chk.sv
module psd_chk #(
   parameter int MIN_N = 192
) (
   input logic clk_i,
   input logic rst_ni,
   input logic div_i,
   input logic err_i,
   input logic tc_i,
   input logic load_i,
   input logic mode_i
);

   logic [31:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (div_i) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != 32'hFFFF_FFFF) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_i |=> !div_i);

   assert_min_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_i && seen_q) |-> (gap_q >= 32'(MIN_N - 1)));

   assert_pulse_on_tc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_i |-> $past(tc_i));

   assert_mode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tc_i && !load_i) |=> $stable(mode_i));

   assert_err_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(err_i));

endmodule

bind pswallow_div psd_chk #(
   .MIN_N (PRE_FIX * MOD_LO * B_MIN)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .div_i  (div_o),
   .err_i  (cfg_err_o),
   .tc_i   (pre_tc),
   .load_i (load_w),
   .mode_i (mode_w)
);

// File: tb/pswallow_div_tb.sv
`timescale 1ns/1ps
module pswallow_div_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [16:0] cfg = '0;
   logic        div_o;
   logic        cfg_err_o;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int pulses = 0;
   string cur_req = "R8";

   // reference model state
   bit exp_div = 1'b0;
   bit exp_err = 1'b0;
   bit need_load = 1'b1;
   int cnt = 0;
   int n_cur = 0;

   always #10 clk = ~clk;

   pswallow_div u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cfg_word_i (cfg),
      .div_o      (div_o),
      .cfg_err_o  (cfg_err_o)
   );

   function automatic int ratio(input logic [16:0] w, output bit bad);
      int a;
      int b;
      a = int'(w[4:0]);
      b = int'(w[16:5]);
      bad = (b < 3) || (b < a);
      if (bad) return 192;
      return 64 * b + 2 * a;
   endfunction

   function automatic logic [16:0] mk(input int a, input int b);
      return {b[11:0], a[4:0]};
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         need_load = 1'b1;
         cnt = 0;
         exp_div = 1'b0;
         exp_err = 1'b0;
      end else begin
         if (need_load) begin
            bit bad;
            n_cur = ratio(cfg, bad);
            exp_err = bad;
            need_load = 1'b0;
         end
         cnt++;
         if (cnt == n_cur) begin
            exp_div = 1'b1;
            cnt = 0;
            need_load = 1'b1;
            pulses++;
         end else begin
            exp_div = 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      tests++;
      if (div_o !== exp_div) begin
         fails++;
         $display("FAIL %s div_o actual=%b expected=%b at cycle %0d", cur_req, div_o, exp_div, cycles);
      end
      tests++;
      if (cfg_err_o !== exp_err) begin
         fails++;
         $display("FAIL %s cfg_err_o actual=%b expected=%b at cycle %0d", cur_req, cfg_err_o, exp_err, cycles);
      end
   end

   task automatic wait_pulses(input int n);
      int target;
      target = pulses + n;
      while (pulses < target) @(negedge clk);
   endtask

   initial begin : watchdog
      while (cycles < 190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d cycles expected=<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R8: reset state, then first period from reset release; R9 minimum ratio
      cfg = mk(0, 3);
      repeat (5) @(negedge clk);
      cur_req = "R9";
      rst_n = 1'b1;
      wait_pulses(3);
      // R1 / R3: mixed long and short prescaler cycles (N = 650)
      cur_req = "R1";
      cfg = mk(5, 10);
      wait_pulses(3);
      // R3: A = B, all cycles long (R9 upper corner, N = 2046)
      cur_req = "R3";
      cfg = mk(31, 31);
      wait_pulses(2);
      // R4: mid-period change only takes effect next period
      cur_req = "R4";
      cfg = mk(7, 40);
      repeat (300) @(negedge clk);
      cfg = mk(2, 6);
      wait_pulses(3);
      // R5: B below minimum
      cur_req = "R5";
      cfg = mk(0, 2);
      wait_pulses(2);
      // R7: error clears on legal word
      cur_req = "R7";
      cfg = mk(1, 4);
      wait_pulses(2);
      // R6: B below A
      cur_req = "R6";
      cfg = mk(9, 4);
      wait_pulses(2);
      // R1: A = 0 with a larger B (N = 6400)
      cur_req = "R1";
      cfg = mk(0, 100);
      wait_pulses(2);
      // R8: reset mid-period clears outputs and restarts
      cur_req = "R8";
      cfg = mk(3, 5);
      repeat (100) @(negedge clk);
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      wait_pulses(2);
      // R2: pulse width checked on every cycle throughout by the model
      cur_req = "R2";
      cfg = mk(31, 4095);
      repeat (50) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule